// File: doc/BRIEF.md
# Interrupt and Low-Power Sequencer

This block runs the control sequences that take an 8-bit processor core away from normal execution: the start-up sequence after reset, entry into a maskable or non-maskable hardware interrupt, the software break instruction, the wait-for-interrupt sleep state and the stop-until-reset state. It holds the 8-bit stack pointer. While a sequence runs it raises `halt` so the core stops executing. During that time the block produces the stack writes for the return address and the status byte. It then produces the two reads of the vector that give the handler address. In the same cycle as the first vector read it pulses the flag updates: the core sets interrupt-disable and clears the decimal flag.

The core presents `insn_bound` for one cycle at each instruction boundary. With it come the address of the next instruction (`insn_pc`), the status byte and the decoded break, wait and stop indications. The block decides at that boundary, in a fixed priority, whether a sequence starts. Stack writes and vector reads leave through valid/ready channels. Once valid is raised, address and data stay stable and the sequence does not advance until ready is seen high at a clock edge. A low ready stalls the block for as long as it lasts. Nothing is dropped.

Top module: `int_lp_sequencer`

## Requirements
- R1: The stack pointer is 8'hFF after reset. Each stack write goes to address {8'h01, sp}, and the pointer drops by one after each accepted write. An interrupt or break writes exactly three bytes: return high byte, return low byte, status.
- R2: After reset the block makes no stack writes. It reads the vector at 16'hFFFC and then at 16'hFFFD, then drops `halt`.
- R3: `set_i` and `clr_d` pulse together for exactly one cycle per sequence, in the cycle the low vector read is accepted. This comes after the status write in interrupts and breaks, and also applies to reset.
- R4: The vector pair is 16'hFFFA/16'hFFFB for the non-maskable interrupt. It is 16'hFFFE/16'hFFFF for the maskable interrupt and for break. The low address is read first.
- R5: The status byte written is `status_in` with bit 5 forced to 1. Bit 4 is 1 for a break and 0 for a hardware interrupt.
- R6: A break writes `insn_pc`+2 as its return address. A hardware interrupt writes `insn_pc`.
- R7: The priority at a boundary is pending non-maskable interrupt, then unmasked maskable interrupt, then break, then stop, then wait. When a break meets an interrupt, the interrupt is taken with return address `insn_pc`, so the break instruction runs again after the handler returns.
- R8: While `i_flag` is 1, `irq_req` starts no sequence at a boundary. A break at the same boundary is then taken normally.
- R9: The non-maskable request acts on its rising edge. An edge that arrives without a boundary is remembered until the next boundary. A level held high does not start a second sequence.
- R10: In the wait state `halt` is high and no bus requests are made. An unmasked `irq_req` starts an interrupt sequence, and a non-maskable edge starts a non-maskable sequence. A masked `irq_req` returns the block to idle with `halt` low and makes no stack writes.
- R11: In the stop state `halt` stays high and no requests are made, whatever the interrupt or boundary inputs do, until reset.
- R12: While a valid is high and its ready is low, the valid stays high and its address and data stay unchanged in the next cycle.
- R13: `halt` is low only when the block is idle. It is high during every sequence, during wait and stop, and from reset until the reset vector reads finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the reset sequence on release |
| irq_req | input | 1 | Maskable interrupt request, level |
| nmi_req | input | 1 | Non-maskable interrupt request, rising edge acts |
| i_flag | input | 1 | Current interrupt-disable flag from the core |
| insn_bound | input | 1 | One-cycle instruction boundary strobe |
| insn_pc | input | 16 | Address of the next instruction at the boundary |
| status_in | input | 8 | Current status byte from the core |
| op_brk | input | 1 | Decoded break instruction at the boundary |
| op_wai | input | 1 | Decoded wait-for-interrupt instruction |
| op_stp | input | 1 | Decoded stop instruction |
| push_valid | output | 1 | Stack write request valid |
| push_ready | input | 1 | Stack write accepted |
| push_addr | output | 16 | Stack write address |
| push_data | output | 8 | Stack write data |
| vec_valid | output | 1 | Vector read request valid |
| vec_ready | input | 1 | Vector read accepted |
| vec_addr | output | 16 | Vector read address |
| set_i | output | 1 | Pulse: set interrupt-disable |
| clr_d | output | 1 | Pulse: clear decimal flag |
| halt | output | 1 | Core execution gate |
| sp | output | 8 | Stack pointer |

## Verification
The bench aims at a break that meets an interrupt at the same boundary. A design that let the break win, or that treated the break as consumed, would write `insn_pc`+2 or set status bit 4, and the break would be lost. A non-maskable level held high across a second boundary catches edge detection done on the level, which would enter the handler a second time. A masked request during wait catches a design that either stays asleep for good or starts an interrupt entry that should not happen. Random ready stalls on both channels expose a pointer that moves, or addresses that change, before acceptance. The stop test drives every wake-up source and expects `halt` to hold until reset.

// File: rtl/int_lp_pkg.sv
package int_lp_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_H, ST_PUSH_L, ST_PUSH_P, ST_VEC_L, ST_VEC_H, ST_WAIT, ST_STOP
  } seq_state_t;

  typedef enum logic [1:0] {
    CS_RST, CS_NMI, CS_IRQ, CS_BRK
  } seq_cause_t;

  localparam int STAT_BRK_BIT = 4;
  localparam int STAT_ONE_BIT = 5;
endpackage

// File: rtl/int_lp_arb.sv
module int_lp_arb
  import int_lp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_req,
  input  logic       irq_req,
  input  logic       i_flag,
  input  logic       insn_bound,
  input  logic       op_brk,
  input  logic       op_wai,
  input  logic       op_stp,
  input  logic       in_idle,
  input  logic       in_wait,
  output logic       ev_go,
  output seq_cause_t ev_cause,
  output logic       go_wait,
  output logic       go_stop,
  output logic       wake_plain
);
  logic nmi_q, nmi_pend, nmi_rise, nmi_any, irq_ok, bound_ev, nmi_ack;

  assign nmi_rise = nmi_req & ~nmi_q;
  assign nmi_any  = nmi_pend | nmi_rise;
  assign irq_ok   = irq_req & ~i_flag;
  assign bound_ev = nmi_any | irq_ok | op_brk;

  assign ev_go = (in_idle & insn_bound & bound_ev) | (in_wait & (nmi_any | irq_ok));

  always_comb begin
    if (nmi_any)     ev_cause = CS_NMI;
    else if (irq_ok) ev_cause = CS_IRQ;
    else             ev_cause = CS_BRK;
  end

  assign go_stop    = in_idle & insn_bound & ~bound_ev & op_stp;
  assign go_wait    = in_idle & insn_bound & ~bound_ev & ~op_stp & op_wai;
  assign wake_plain = in_wait & ~nmi_any & ~irq_ok & irq_req;
  assign nmi_ack    = ev_go & (ev_cause == CS_NMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_req;
      nmi_pend <= (nmi_pend | nmi_rise) & ~nmi_ack;
    end
  end

  AST_NMI_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_ack |=> !nmi_pend); // R9
  AST_NMI_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_pend && nmi_q && nmi_req) |-> (ev_cause != CS_NMI)); // R9
endmodule

// File: rtl/int_lp_stack.sv
module int_lp_stack #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  output logic [DW-1:0] sp,
  output logic [AW-1:0] push_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= '1;
    else if (dec) sp <= sp - DW'(1);
  end

  assign push_addr = {STACK_PAGE, sp};

  AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == $past(sp) - DW'(1)); // R1
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec |=> $stable(sp)); // R1
endmodule

// File: rtl/int_lp_sequencer.sv
module int_lp_sequencer
  import int_lp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-DW-1:0] STACK_PAGE = 'h01,
  parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
  parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE,
  parameter int BRK_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic          nmi_req,
  input  logic          i_flag,
  input  logic          insn_bound,
  input  logic [AW-1:0] insn_pc,
  input  logic [DW-1:0] status_in,
  input  logic          op_brk,
  input  logic          op_wai,
  input  logic          op_stp,
  output logic          push_valid,
  input  logic          push_ready,
  output logic [AW-1:0] push_addr,
  output logic [DW-1:0] push_data,
  output logic          vec_valid,
  input  logic          vec_ready,
  output logic [AW-1:0] vec_addr,
  output logic          set_i,
  output logic          clr_d,
  output logic          halt,
  output logic [DW-1:0] sp
);
  localparam int HI = AW - DW;

  seq_state_t state, state_nx;
  seq_cause_t cause, ev_cause;
  logic [AW-1:0] ret_q, ret_new, vec_base;
  logic [DW-1:0] stat_q, stat_new;
  logic ev_go, go_wait, go_stop, wake_plain, push_hs, vec_hs;

  int_lp_arb u_arb (
    .clk, .rst_n, .nmi_req, .irq_req, .i_flag, .insn_bound, .op_brk, .op_wai, .op_stp,
    .in_idle(state == ST_IDLE), .in_wait(state == ST_WAIT),
    .ev_go, .ev_cause, .go_wait, .go_stop, .wake_plain
  );

  int_lp_stack #(.AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_stack (
    .clk, .rst_n, .dec(push_hs), .sp, .push_addr
  );

  assign push_valid = (state == ST_PUSH_H) | (state == ST_PUSH_L) | (state == ST_PUSH_P);
  assign vec_valid  = (state == ST_VEC_L) | (state == ST_VEC_H);
  assign push_hs    = push_valid & push_ready;
  assign vec_hs     = vec_valid & vec_ready;
  assign halt       = (state != ST_IDLE);
  assign set_i      = vec_hs & (state == ST_VEC_L);
  assign clr_d      = vec_hs & (state == ST_VEC_L);

  always_comb begin
    stat_new               = status_in;
    stat_new[STAT_ONE_BIT] = 1'b1;
    stat_new[STAT_BRK_BIT] = (ev_cause == CS_BRK);
    ret_new = (ev_cause == CS_BRK) ? insn_pc + AW'(BRK_LEN) : insn_pc;
  end

  always_comb begin
    case (state)
      ST_PUSH_H: push_data = ret_q[AW-1:HI];
      ST_PUSH_L: push_data = ret_q[DW-1:0];
      default:   push_data = stat_q;
    endcase
  end

  always_comb begin
    case (cause)
      CS_NMI:  vec_base = VEC_NMI;
      CS_RST:  vec_base = VEC_RST;
      default: vec_base = VEC_IRQ;
    endcase
    vec_addr = (state == ST_VEC_H) ? vec_base + AW'(1) : vec_base;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (ev_go)        state_nx = ST_PUSH_H;
        else if (go_stop) state_nx = ST_STOP;
        else if (go_wait) state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (ev_go)           state_nx = ST_PUSH_H;
        else if (wake_plain) state_nx = ST_IDLE;
      end
      ST_PUSH_H: if (push_hs) state_nx = ST_PUSH_L;
      ST_PUSH_L: if (push_hs) state_nx = ST_PUSH_P;
      ST_PUSH_P: if (push_hs) state_nx = ST_VEC_L;
      ST_VEC_L:  if (vec_hs)  state_nx = ST_VEC_H;
      ST_VEC_H:  if (vec_hs)  state_nx = ST_IDLE;
      default:   state_nx = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_VEC_L;
      cause  <= CS_RST;
      ret_q  <= '0;
      stat_q <= '0;
    end else begin
      state <= state_nx;
      if (ev_go) begin
        cause  <= ev_cause;
        ret_q  <= ret_new;
        stat_q <= stat_new;
      end
    end
  end

  AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_addr[AW-1:HI] == STACK_PAGE); // R1
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> push_valid && $stable(push_addr) && $stable(push_data)); // R12
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> vec_valid && $stable(vec_addr)); // R12
  AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> vec_valid && vec_addr == $past(vec_addr) + AW'(1)); // R4
  AST_RST_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == CS_RST) |-> !push_valid); // R2
  AST_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i || clr_d) |-> (set_i && clr_d && vec_hs)); // R3
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |=> halt && !push_valid && !vec_valid); // R11
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> halt && !push_valid && !vec_valid); // R10
endmodule

// File: tb/int_lp_sequencer_bench.sv
module int_lp_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n, irq_req, nmi_req, i_flag, insn_bound, op_brk, op_wai, op_stp;
  logic [15:0] insn_pc, push_addr, vec_addr;
  logic [7:0] status_in, push_data, sp;
  logic push_valid, push_ready, vec_valid, vec_ready, set_i, clr_d, halt;

  int total = 0, bad = 0;
  logic [15:0] pa [0:7];
  logic [7:0]  pd [0:7];
  logic [15:0] va [0:3];
  int np, nv, nflag;
  bit flag_bad;
  logic [7:0] exp_sp;

  localparam int C_RST = 0, C_NMI = 1, C_IRQ = 2, C_BRK = 3;

  always #5 clk = ~clk;

  int_lp_sequencer u_int_lp_sequencer (
    .clk, .rst_n, .irq_req, .nmi_req, .i_flag, .insn_bound, .insn_pc, .status_in,
    .op_brk, .op_wai, .op_stp, .push_valid, .push_ready, .push_addr, .push_data,
    .vec_valid, .vec_ready, .vec_addr, .set_i, .clr_d, .halt, .sp
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_vec(input int c);
    case (c)
      C_NMI:   return 16'hFFFA;
      C_RST:   return 16'hFFFC;
      default: return 16'hFFFE;
    endcase
  endfunction

  function automatic logic [7:0] exp_stat(input logic [7:0] st, input bit brk);
    return (st | 8'h20) & ~8'h10 | (brk ? 8'h10 : 8'h00);
  endfunction

  function automatic int pick_cause(input bit nmi, input bit irq, input bit imask, input bit brk);
    if (nmi) return C_NMI;
    if (irq && !imask) return C_IRQ;
    if (brk) return C_BRK;
    return -1;
  endfunction

  // Called at a falling edge; returns 1 ns after the falling edge where halt is seen low.
  task automatic collect(input bit rnd);
    bit ppv = 0, ppr = 0, pvv = 0, pvr = 0;
    logic [15:0] ppa = '0, pva = '0;
    logic [7:0] ppd = '0;
    np = 0; nv = 0; nflag = 0; flag_bad = 0;
    for (int g = 0; g < 400; g++) begin
      push_ready = rnd ? ($urandom % 4 != 0) : 1'b1;
      vec_ready  = rnd ? ($urandom % 4 != 0) : 1'b1;
      #1;
      if (ppv && !ppr)
        check(push_valid && push_addr == ppa && push_data == ppd, "R12 push hold", {push_addr, push_data, 8'h0}, {ppa, ppd, 8'h0});
      if (pvv && !pvr)
        check(vec_valid && vec_addr == pva, "R12 vector hold", vec_addr, pva);
      if (!halt) break;
      if (push_valid && push_ready) begin
        if (np < 8) begin pa[np] = push_addr; pd[np] = push_data; end
        np++;
      end
      if (vec_valid && vec_ready) begin
        if (nv < 4) va[nv] = vec_addr;
        nv++;
      end
      if (set_i || clr_d) begin
        nflag++;
        if (!(set_i && clr_d && vec_valid && vec_ready && nv == 1 && (np == 0 || np == 3))) flag_bad = 1;
      end
      ppv = push_valid; ppr = push_ready; ppa = push_addr; ppd = push_data;
      pvv = vec_valid;  pvr = vec_ready;  pva = vec_addr;
      @(negedge clk);
    end
  endtask

  task automatic verify(input int c, input logic [15:0] pc, input logic [7:0] st, input string tag);
    logic [15:0] ret;
    int enp;
    ret = (c == C_BRK) ? pc + 16'd2 : pc;
    enp = (c == C_RST) ? 0 : 3;
    check(np == enp, {"R1 R2 push count ", tag}, np, enp);
    if (np == 3 && enp == 3) begin
      for (int i = 0; i < 3; i++) begin
        logic [7:0] s;
        s = exp_sp - 8'(i);
        check(pa[i] == {8'h01, s}, {"R1 push address ", tag}, pa[i], {8'h01, s});
      end
      check(pd[0] == ret[15:8], {"R6 return high ", tag}, pd[0], ret[15:8]);
      check(pd[1] == ret[7:0], {"R6 return low ", tag}, pd[1], ret[7:0]);
      check(pd[2] == exp_stat(st, c == C_BRK), {"R5 status byte ", tag}, pd[2], exp_stat(st, c == C_BRK));
      exp_sp = exp_sp - 8'd3;
    end
    check(nv == 2, {"R4 vector count ", tag}, nv, 2);
    if (nv == 2) begin
      check(va[0] == exp_vec(c), {"R4 vector low ", tag}, va[0], exp_vec(c));
      check(va[1] == exp_vec(c) + 16'd1, {"R4 vector high ", tag}, va[1], exp_vec(c) + 16'd1);
    end
    check(nflag == 1 && !flag_bad, {"R3 flag pulse ", tag}, nflag, 1);
    check(sp == exp_sp, {"R1 stack pointer ", tag}, sp, exp_sp);
    check(!halt, {"R13 halt low when idle ", tag}, halt, 0);
  endtask

  task automatic bound(input logic [15:0] pc, input logic [7:0] st, input bit brk, input bit wai,
                       input bit stp, input bit nmi_up);
    @(negedge clk);
    insn_bound = 1; insn_pc = pc; status_in = st; op_brk = brk; op_wai = wai; op_stp = stp;
    if (nmi_up) nmi_req = 1;
    @(negedge clk);
    insn_bound = 0; op_brk = 0; op_wai = 0; op_stp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; vec_ready = 0; push_ready = 0; nmi_req = 0; irq_req = 0;
    #1;
    check(halt && sp == 8'hFF && vec_valid && vec_addr == 16'hFFFC && !push_valid, "R2 R13 reset state",
          {halt, push_valid, vec_valid, sp, vec_addr}, {3'b101, 8'hFF, 16'hFFFC});
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_sp = 8'hFF;
    collect(1);
    verify(C_RST, 16'h0, 8'h0, "reset");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; irq_req = 0; nmi_req = 0; i_flag = 0; insn_bound = 0; insn_pc = '0;
    status_in = '0; op_brk = 0; op_wai = 0; op_stp = 0; push_ready = 0; vec_ready = 0;
    do_reset();

    // plain maskable interrupt
    irq_req = 1; i_flag = 0;
    bound(16'h1234, 8'hC3, 0, 0, 0, 0); collect(0); verify(C_IRQ, 16'h1234, 8'hC3, "irq");
    irq_req = 0;
    // break alone
    bound(16'h80FF, 8'h08, 1, 0, 0, 0); collect(1); verify(C_BRK, 16'h80FF, 8'h08, "brk");
    // break meets interrupt: interrupt first, break address kept (R7)
    irq_req = 1;
    bound(16'h4000, 8'h18, 1, 0, 0, 0); collect(1); verify(C_IRQ, 16'h4000, 8'h18, "R7 brk+irq");
    // masked request ignored (R8)
    i_flag = 1;
    bound(16'h5000, 8'h04, 0, 0, 0, 0); #1;
    check(!halt && !push_valid, "R8 masked irq ignored", halt, 0);
    bound(16'h5000, 8'h04, 1, 0, 0, 0); collect(0); verify(C_BRK, 16'h5000, 8'h04, "R8 brk under mask");
    // NMI beats everything; held level does not retrigger (R7, R9)
    i_flag = 0;
    bound(16'h6000, 8'h00, 1, 1, 1, 1); collect(1); verify(C_NMI, 16'h6000, 8'h00, "R7 nmi priority");
    irq_req = 0;
    bound(16'h6100, 8'h00, 0, 0, 0, 0); #1;
    check(!halt, "R9 held nmi no retrigger", halt, 0);
    nmi_req = 0;
    // NMI edge with no boundary is remembered (R9)
    @(negedge clk); nmi_req = 1; @(negedge clk); nmi_req = 0; repeat (3) @(negedge clk);
    #1; check(!halt, "R9 latched nmi waits for boundary", halt, 0);
    bound(16'h6200, 8'h01, 0, 0, 0, 0); collect(1); verify(C_NMI, 16'h6200, 8'h01, "R9 latched nmi");
    // stop beats wait at one boundary, wait alone enters wait
    bound(16'h7000, 8'h00, 0, 1, 0, 0); #1;
    for (int k = 0; k < 5; k++) begin
      check(halt && !push_valid && !vec_valid, "R10 wait quiet", {halt, push_valid, vec_valid}, 3'b100);
      @(negedge clk); #1;
    end
    @(negedge clk); irq_req = 1; i_flag = 0; insn_pc = 16'h7001;
    @(negedge clk); collect(0); verify(C_IRQ, 16'h7001, 8'h00, "R10 wait wake irq");
    irq_req = 0;
    bound(16'h7100, 8'h00, 0, 1, 0, 0);
    @(negedge clk); irq_req = 1; i_flag = 1;
    @(negedge clk); #1;
    check(!halt && !push_valid && !vec_valid && sp == exp_sp, "R10 masked wake resumes", {halt, sp}, {1'b0, exp_sp});
    irq_req = 0; i_flag = 0;
    bound(16'h7200, 8'h00, 0, 1, 0, 0);
    @(negedge clk); nmi_req = 1; insn_pc = 16'h7201;
    @(negedge clk); collect(1); verify(C_NMI, 16'h7201, 8'h00, "R10 wait wake nmi");
    nmi_req = 0;
    // stop: nothing wakes it except reset (R11, R7 stop over wait)
    bound(16'h7300, 8'h00, 0, 1, 1, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      irq_req = 1; i_flag = 0; nmi_req = ~nmi_req; insn_bound = 1; op_brk = 1;
      #1; check(halt && !push_valid && !vec_valid, "R11 stop holds", {halt, push_valid, vec_valid}, 3'b100);
    end
    @(negedge clk); insn_bound = 0; op_brk = 0; irq_req = 0; nmi_req = 0;
    do_reset();

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      int kind, c;
      bit ni, ir, im, bk;
      logic [15:0] pc;
      logic [7:0] st;
      kind = $urandom % 6;
      pc = 16'($urandom); st = 8'($urandom);
      ni = (kind == 4); ir = (kind == 0 || kind == 2 || kind == 5 || kind == 4);
      im = (kind == 5); bk = (kind == 1 || kind == 2 || kind == 4 || (kind == 5 && ($urandom % 2 == 1)));
      c = pick_cause(ni, ir, im, bk);
      irq_req = ir; i_flag = im;
      bound(pc, st, bk, 0, 0, ni);
      if (c < 0) begin
        #1; check(!halt && !push_valid, "R8 random masked", halt, 0);
      end else begin
        collect(1); verify(c, pc, st, "R7 random");
      end
      irq_req = 0; nmi_req = 0; i_flag = 0;
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule